// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog built from an 8-bit up-counter and an 8-bit control/status register. Software reaches both through a small register bus. The bus has one write strobe, one address bit and a write word. Any write whose top byte does not carry the correct key is dropped, so stray stores cannot stop the watchdog or move its count by accident. The counter has one key and the control register has a different one. Reads return only the stored 8-bit value, so the key never has to be read back.

A 3-bit select field picks the tick rate. It divides the input clock by 32 times a power of two, from 32 up to 4096. When the counter wraps from 0xFF to 0x00, the block sets a sticky overflow flag. It then signals in one of two ways, chosen by a mode bit:

- a single-cycle watchdog reset pulse, or
- a level interrupt that stays high until software clears the flag.

The `BUS_W` parameter selects a 16-bit or a 32-bit bus. In both, the key sits in the top byte of the write word and the value in the bottom byte. The 32-bit build returns reads zero-extended to 32 bits.

Top module: `wdt_keyed_top`

## Requirements
- R1: A write to address 0 whose top byte (bits BUS_W-1 down to BUS_W-8) equals 0x5A loads bits 7:0 into the counter at the next clock edge.
- R2: A write to address 1 whose top byte equals 0xA5 updates the control register from bits 7:0. Bit 7 is enable, bit 6 is mode (1 = reset pulse, 0 = interrupt) and bits 2:0 are the divider select.
- R3: A write whose top byte is not the key for the addressed register is ignored: the counter, enable, mode and select keep their values.
- R4: The read data shows the counter at address 0 and the control register at address 1. Control read layout: bit 7 enable, bit 6 mode, bit 3 overflow flag, bits 2:0 select, bits 5:4 read 0. A 16-bit build has an 8-bit read port; a 32-bit build returns the byte zero-extended to 32 bits.
- R5: With enable set, the counter advances once every 32<<sel input clock cycles (sel 0 gives /32 and sel 7 gives /4096).
- R6: After reset the counter is 0 and the control register is 0 (disabled, divide by 32), and both outputs are low.
- R7: The prescaler restarts when the timer is disabled or when an accepted control write changes the select. The first tick after enabling, or after a select change, comes a full divider period later.
- R8: A tick at counter value 0xFF wraps the counter to 0x00 and sets the overflow flag in the same edge.
- R9: The overflow flag clears only through an accepted control write with bit 3 = 0. Writing 1 to bit 3 leaves the flag unchanged; it neither sets it nor clears it.
- R10: In reset mode (bit 6 = 1), `wdt_rst_o` is high for exactly the one cycle that follows the clock edge at which the counter wraps.
- R11: `wdt_irq_o` is high whenever the overflow flag is set and the mode bit is 0.
- R12: An accepted counter write in the same cycle as a tick wins, and the tick is lost. While disabled, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 1 | Register select: 0 counter, 1 control |
| bus_wdata_i | input | BUS_W | Write word: key in top byte, value in bits 7:0 |
| bus_rdata_o | output | 8 or 32 | Read data for the addressed register |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |
| wdt_irq_o | output | 1 | Overflow interrupt level |

## Verification
The assertions check the following on every cycle:
- a keyed counter write lands with its byte, and a badly keyed write changes nothing;
- a wrap always leaves the flag set;
- the flag only falls after a clearing write;
- the reset output never lasts more than a cycle;
- a disabled timer holds its count;
- a tick never comes in the cycle that the enable rises.

The exact tick spacing for each divider, the prescaler restart when the select changes, the collision between a counter write and a tick, and the equality of the 16-bit and 32-bit builds are shown only by the bench's scenarios. Those scenarios run against a cycle-level reference model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DAT_W     = 8;
    localparam int KEY_W     = 8;
    localparam int SEL_W     = 3;
    localparam int BASE_LOG2 = 5;

    localparam logic [KEY_W-1:0] KEY_COUNT   = 8'h5A;
    localparam logic [KEY_W-1:0] KEY_CONTROL = 8'hA5;

    localparam int BIT_EN   = 7;
    localparam int BIT_MODE = 6;
    localparam int BIT_FLAG = 3;

    typedef struct packed {
        logic             enable;
        logic             rst_mode;
        logic             flag;
        logic [SEL_W-1:0] sel;
    } wdt_ctl_t;

    function automatic logic [DAT_W-1:0] ctl_to_byte(wdt_ctl_t c);
        logic [DAT_W-1:0] r;
        r                = '0;
        r[BIT_EN]        = c.enable;
        r[BIT_MODE]      = c.rst_mode;
        r[BIT_FLAG]      = c.flag;
        r[SEL_W-1:0]     = c.sel;
        return r;
    endfunction

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic             cnt_wr_o,
    output logic             ctl_wr_o,
    output logic [DAT_W-1:0] data_o
);
    localparam int MID_W = BUS_W - KEY_W - DAT_W;

    logic [KEY_W-1:0] key;

    always_comb begin
        key      = wdata_i[BUS_W-1 -: KEY_W];
        data_o   = wdata_i[DAT_W-1:0];
        cnt_wr_o = wr_i && !addr_i && (key == KEY_COUNT);
        ctl_wr_o = wr_i &&  addr_i && (key == KEY_CONTROL);
    end

    generate
        if (MID_W > 0) begin : g_mid
            logic unused_mid;
            assign unused_mid = ^wdata_i[DAT_W +: MID_W];
        end
    endgenerate

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int PRE_W   = BASE_LOG2 + MAX_SEL;

    typedef struct packed {
        logic [PRE_W-1:0] count;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic [SEL_W-1:0] shr;
    logic             tick;

    always_comb begin
        shr   = SEL_W'(MAX_SEL) - sel_i;
        limit = {PRE_W{1'b1}} >> shr;
        tick  = run_i && (st_q.count == limit);
        st_d  = st_q;
        if (!run_i || restart_i || tick) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // R5: the shortest divider is far longer than one cycle
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R7: a freshly enabled prescaler starts from zero
    assert_no_early_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> !tick_o);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_i,
    input  logic             ctl_wr_i,
    input  logic [DAT_W-1:0] data_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             restart_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [DAT_W-1:0] ctl_o,
    output logic             ovf_o,
    output logic             rst_pulse_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wdt_ctl_t         ctl;
        logic             rst_pulse;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        wrap = tick_i && (st_q.cnt == '1) && !cnt_wr_i;

        if (cnt_wr_i) begin
            st_d.cnt = data_i[CNT_W-1:0];
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (ctl_wr_i) begin
            st_d.ctl.enable   = data_i[BIT_EN];
            st_d.ctl.rst_mode = data_i[BIT_MODE];
            st_d.ctl.sel      = data_i[SEL_W-1:0];
            st_d.ctl.flag     = st_q.ctl.flag & data_i[BIT_FLAG];
        end
        if (wrap) begin
            st_d.ctl.flag = 1'b1;
        end

        st_d.rst_pulse = wrap && st_q.ctl.rst_mode;

        restart_o = ctl_wr_i && (!data_i[BIT_EN] || (data_i[SEL_W-1:0] != st_q.ctl.sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o       = st_q.ctl.enable;
    assign sel_o       = st_q.ctl.sel;
    assign cnt_o       = st_q.cnt;
    assign ctl_o       = ctl_to_byte(st_q.ctl);
    assign ovf_o       = wrap;
    assign rst_pulse_o = st_q.rst_pulse;
    assign irq_o       = st_q.ctl.flag && !st_q.ctl.rst_mode;

    assert_flag_after_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.ctl.flag);

    assert_flag_clear_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ctl.flag) |-> $past(ctl_wr_i && !data_i[BIT_FLAG]));

    assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);

    assert_pulse_with_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |-> st_q.ctl.flag);

    assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl.enable && !cnt_wr_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int CNT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr_i,
    input  logic                            bus_addr_i,
    input  logic [BUS_W-1:0]                bus_wdata_i,
    output logic [((BUS_W==32)?32:8)-1:0]   bus_rdata_o,
    output logic                            wdt_rst_o,
    output logic                            wdt_irq_o
);
    localparam int RD_W = (BUS_W == 32) ? 32 : 8;

    logic             cnt_wr, ctl_wr, run, restart, tick, ovf;
    logic [DAT_W-1:0] wr_byte, ctl_byte, rd_byte;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;

    wdt_key_decode #(.BUS_W(BUS_W)) i_decode (
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .cnt_wr_o (cnt_wr),
        .ctl_wr_o (ctl_wr),
        .data_o   (wr_byte)
    );

    wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .sel_i     (sel),
        .tick_o    (tick)
    );

    wdt_core #(.CNT_W(CNT_W)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_wr_i    (cnt_wr),
        .ctl_wr_i    (ctl_wr),
        .data_i      (wr_byte),
        .tick_i      (tick),
        .run_o       (run),
        .restart_o   (restart),
        .sel_o       (sel),
        .cnt_o       (cnt),
        .ctl_o       (ctl_byte),
        .ovf_o       (ovf),
        .rst_pulse_o (wdt_rst_o),
        .irq_o       (wdt_irq_o)
    );

    always_comb begin
        rd_byte = bus_addr_i ? ctl_byte : DAT_W'(cnt);
    end

    generate
        if (RD_W > DAT_W) begin : g_wide_read
            assign bus_rdata_o = {{(RD_W-DAT_W){1'b0}}, rd_byte};
        end else begin : g_byte_read
            assign bus_rdata_o = rd_byte;
        end
    endgenerate

    assert_keyed_count_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_addr_i && bus_wdata_i[BUS_W-1 -: KEY_W] == KEY_COUNT)
        |=> cnt == $past(bus_wdata_i[CNT_W-1:0]));

    assert_bad_key_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_addr_i && bus_wdata_i[BUS_W-1 -: KEY_W] != KEY_COUNT && !tick)
        |=> $stable(cnt));

    assert_bad_key_control_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i && bus_wdata_i[BUS_W-1 -: KEY_W] != KEY_CONTROL)
        |=> $stable({ctl_byte[BIT_EN], ctl_byte[BIT_MODE], ctl_byte[SEL_W-1:0]}));

    assert_wrap_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> run);

endmodule

// File: tb/test_wdt_keyed_top.sv
module test_wdt_keyed_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr    = 1'b0;
    logic       addr  = 1'b0;
    logic [7:0] key   = 8'h00;
    logic [7:0] dbyte = 8'h00;

    logic [15:0] wd16;
    logic [31:0] wd32;
    assign wd16 = {key, dbyte};
    assign wd32 = {key, 16'h3C3C, dbyte};

    logic [7:0]  rd16;
    logic [31:0] rd32;
    logic        rst16, irq16, rst32, irq32;

    wdt_keyed_top #(.BUS_W(16)) i_wdt_keyed_top (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wd16), .bus_rdata_o(rd16), .wdt_rst_o(rst16), .wdt_irq_o(irq16));

    wdt_keyed_top #(.BUS_W(32)) i_wdt_keyed_top_w32 (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wd32), .bus_rdata_o(rd32), .wdt_rst_o(rst32), .wdt_irq_o(irq32));

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // behavioural reference state
    int m_cnt = 0, m_en = 0, m_mode = 0, m_flag = 0, m_sel = 0, m_pre = 0, m_rst = 0;

    function automatic int m_ctl();
        return m_en * 128 + m_mode * 64 + m_flag * 8 + m_sel;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        exp_rd = addr ? m_ctl() : m_cnt;
        check(int'(rd16) == exp_rd, "R4 per-cycle read 16-bit", int'(rd16), exp_rd);
        check(rd32 == 32'(exp_rd), "R4 per-cycle read 32-bit", int'(rd32), exp_rd);
        check(int'(rst16) == m_rst && int'(rst32) == m_rst, "R10 per-cycle reset output",
              int'(rst16), m_rst);
        check(int'(irq16) == (m_flag & ~m_mode & 1) && irq32 == irq16,
              "R11 per-cycle interrupt", int'(irq16), m_flag & ~m_mode & 1);
    endtask

    task automatic model_step();
        int  div, n_pre, n_flag;
        bit  tick, wc, wk, ovf;
        div  = 32 << m_sel;
        tick = (m_en != 0) && (m_pre == div - 1);
        wc   = wr && !addr && key == 8'h5A;
        wk   = wr &&  addr && key == 8'hA5;
        ovf  = tick && m_cnt == 255 && !wc;
        if (wk && (!dbyte[7] || int'(dbyte[2:0]) != m_sel)) n_pre = 0;
        else if (m_en == 0 || tick)                           n_pre = 0;
        else                                                  n_pre = m_pre + 1;
        n_flag = m_flag;
        if (wk)  n_flag = m_flag & int'(dbyte[3]);
        if (ovf) n_flag = 1;
        m_rst = (ovf && m_mode != 0) ? 1 : 0;
        if (wc)        m_cnt = int'(dbyte);
        else if (tick) m_cnt = (m_cnt + 1) % 256;
        if (wk) begin
            m_en   = int'(dbyte[7]);
            m_mode = int'(dbyte[6]);
            m_sel  = int'(dbyte[2:0]);
        end
        m_pre  = n_pre;
        m_flag = n_flag;
    endtask

    task automatic cycle(input bit w, input bit a, input logic [7:0] k, input logic [7:0] d);
        @(negedge clk);
        compare_all();
        wr = w; addr = a; key = k; dbyte = d;
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, addr, 8'h00, 8'h00);
    endtask

    task automatic wr_cnt(input logic [7:0] d); cycle(1'b1, 1'b0, 8'h5A, d); endtask
    task automatic wr_ctl(input logic [7:0] d); cycle(1'b1, 1'b1, 8'hA5, d); endtask

    // only called right after idle(), so no write is pending
    task automatic peek(input bit a, output int v);
        addr = a;
        #1;
        v = int'(rd16);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        idle(1);
        peek(1'b0, v); check(v == 0, "R6 counter after reset", v, 0);
        peek(1'b1, v); check(v == 0, "R6 control after reset", v, 0);
        check(rst16 == 0 && irq16 == 0, "R6 outputs after reset", int'(rst16), 0);

        // R1 keyed counter write
        wr_cnt(8'h12); idle(1);
        peek(1'b0, v); check(v == 'h12, "R1 keyed counter write", v, 'h12);
        check(rd32 == 32'h12, "R4 32-bit read zero-extended", int'(rd32), 'h12);

        // R3 rejected writes
        cycle(1'b1, 1'b0, 8'hA5, 8'h77); idle(1);
        peek(1'b0, v); check(v == 'h12, "R3 counter key swapped", v, 'h12);
        cycle(1'b1, 1'b0, 8'h5B, 8'h99); idle(1);
        peek(1'b0, v); check(v == 'h12, "R3 counter key off by one", v, 'h12);
        cycle(1'b1, 1'b1, 8'h5A, 8'hC7); idle(1);
        peek(1'b1, v); check(v == 0, "R3 control wrong key", v, 0);

        // R2 / R4 / R9 control layout
        wr_ctl(8'h05); idle(1);
        peek(1'b1, v); check(v == 'h05, "R2 keyed control write", v, 'h05);
        wr_ctl(8'h3F); idle(1);
        peek(1'b1, v); check(v == 'h07, "R4 R9 spare bits and flag not settable", v, 'h07);

        // R12 disabled counter holds
        wr_ctl(8'h00); wr_cnt(8'h33); idle(100);
        peek(1'b0, v); check(v == 'h33, "R12 disabled hold", v, 'h33);

        // R5 divide by 64
        wr_cnt(8'h40); wr_ctl(8'h81); idle(64);
        peek(1'b0, v); check(v == 'h40, "R5 before first /64 tick", v, 'h40);
        idle(1);
        peek(1'b0, v); check(v == 'h41, "R5 first /64 tick", v, 'h41);

        // R7 select change restarts prescaler
        wr_ctl(8'h00); wr_cnt(8'h10); wr_ctl(8'h81); idle(40);
        wr_ctl(8'h80); idle(32);
        peek(1'b0, v); check(v == 'h10, "R7 no tick before restarted period", v, 'h10);
        idle(1);
        peek(1'b0, v); check(v == 'h11, "R7 tick a full /32 period after change", v, 'h11);

        // R12 write wins over tick
        wr_ctl(8'h00); wr_cnt(8'h20); wr_ctl(8'h80); idle(31);
        wr_cnt(8'h50); idle(1);
        peek(1'b0, v); check(v == 'h50, "R12 write beats tick", v, 'h50);
        idle(31);
        peek(1'b0, v); check(v == 'h50, "R12 tick lost", v, 'h50);
        idle(1);
        peek(1'b0, v); check(v == 'h51, "R12 next tick", v, 'h51);

        // R8 / R10 reset-mode overflow
        wr_ctl(8'h00); wr_cnt(8'hFF); wr_ctl(8'hC0); idle(32);
        check(rst16 == 0, "R10 no pulse before wrap", int'(rst16), 0);
        idle(1);
        peek(1'b0, v); check(v == 0, "R8 counter wraps to 0", v, 0);
        check(rst16 == 1 && rst32 == 1, "R10 pulse after wrap", int'(rst16), 1);
        check(irq16 == 0, "R11 no interrupt in reset mode", int'(irq16), 0);
        idle(1);
        check(rst16 == 0, "R10 pulse lasts one cycle", int'(rst16), 0);
        peek(1'b1, v); check(v == 'hC8, "R8 flag set", v, 'hC8);

        // R11 / R9 interrupt mode and clearing
        wr_ctl(8'h00); wr_cnt(8'hFF); wr_ctl(8'h80); idle(33);
        check(irq16 == 1 && rst16 == 0, "R11 interrupt on wrap", int'(irq16), 1);
        wr_ctl(8'h88); idle(1);
        peek(1'b1, v); check(v == 'h88, "R9 writing 1 keeps flag", v, 'h88);
        wr_ctl(8'h80); idle(1);
        peek(1'b1, v); check(v == 'h80, "R9 writing 0 clears flag", v, 'h80);
        check(irq16 == 0, "R11 interrupt drops with flag", int'(irq16), 0);

        // R5 divide by 4096
        wr_ctl(8'h00); wr_cnt(8'hFE); wr_ctl(8'h87); idle(8192);
        peek(1'b1, v); check(v == 'h87, "R5 no wrap before 2 x 4096 cycles", v, 'h87);
        idle(1);
        peek(1'b1, v); check(v == 'h8F, "R5 wrap at 2 x 4096 cycles", v, 'h8F);

        idle(2);
        finish_run();
    end

endmodule